// File: doc/BRIEF.md
# Dual-Port RAM with Collision Arbitration

This block is a synchronous, single-clock memory of 2048 bytes with two independent access sides, left and right. Each side has its own active-low select, active-low write strobe, active-low read-output enable, an 11-bit address, a write byte and a read byte. Reads have one cycle of latency. The two sides may reach the same word at the same time. When that happens an arbiter grants the word to one side and pulls the other side's active-low busy flag low.

Priority goes to the side that was already selected at that address in the previous cycle. If both sides arrive in the same cycle, the left side wins. While a side holds busy, its writes are dropped. Its read byte is also held frozen, so a write by the winning side cannot tear the value it sees. A grant status output reports which side won the current collision.

A slave setting turns the busy pins into inputs: the arbiter goes quiet and each side's write is blocked while its busy input is low. Memory access is random and single-word, so the data pins are plain: there is no valid/ready handshake and no back-pressure. Every accepted operation completes in one cycle.

Top module: `dpr_collision_ram`

## Requirements
- R1: A side writes its byte at a rising edge only when its select and write strobe are both low at that edge. A read (select low, write strobe high, output enable low) presents the addressed byte on its read bus after that edge. In any other cycle the read bus becomes 0 after the edge.
- R2: In master operation a busy output is low in the same cycle only when both sides are selected, their addresses are equal and the other side holds the grant. At most one busy output is low. Busy returns high in the cycle the match ends.
- R3: A side that was selected at the same address in the previous cycle wins against a side that has just arrived, by selecting or by changing address. The new arrival gets busy.
- R4: If both sides start to match in the same cycle with neither settled, the left side wins.
- R5: A grant, once given, holds for as long as the addresses keep matching, whatever later settles.
- R6: A write strobe from a side whose busy is low changes no memory content.
- R7: A losing side that keeps reading reloads its byte in its first busy cycle. After that its read bus holds while busy stays low and its write strobe is unchanged. It updates again after busy rises or the strobe toggles.
- R8: With slave_en high, both busy outputs stay high and grant reads 0. A side's write is then blocked while its busy input is low, and proceeds once that input is high.
- R9: grant encodes the winner as 2'b01 for left, 2'b10 for right and 2'b00 for no collision.
- R10: During and just after reset both read buses are 0, both busy outputs are high and grant is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| slave_en | input | 1 | 1: busy pins act as write-inhibit inputs |
| ce_l_n | input | 1 | left select, active low |
| we_l_n | input | 1 | left write strobe, active low |
| oe_l_n | input | 1 | left read-output enable, active low |
| addr_l | input | 11 | left address |
| wdata_l | input | 8 | left write byte |
| rdata_l | output | 8 | left read byte |
| busy_l_n | output | 1 | left busy flag, active low (master) |
| busy_l_in_n | input | 1 | left write inhibit, active low (slave) |
| ce_r_n | input | 1 | right select, active low |
| we_r_n | input | 1 | right write strobe, active low |
| oe_r_n | input | 1 | right read-output enable, active low |
| addr_r | input | 11 | right address |
| wdata_r | input | 8 | right write byte |
| rdata_r | output | 8 | right read byte |
| busy_r_n | output | 1 | right busy flag, active low (master) |
| busy_r_in_n | input | 1 | right write inhibit, active low (slave) |
| grant | output | 2 | collision winner status |

## Verification
Two functions can land in the same clock edge: the winning side's write to the shared word, and the losing side's frozen read of that same word. The bench parks one side reading a word and brings the other onto it. It then has the winner write a new byte while the loser keeps reading. The loser must show the old byte for as long as the collision lasts and the new byte one edge after the winner leaves. A same-cycle arrival of both sides is provoked separately and judged by the grant code and the busy pins.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
  typedef enum logic [1:0] {
    GRANT_NONE  = 2'b00,
    GRANT_LEFT  = 2'b01,
    GRANT_RIGHT = 2'b10
  } grant_e;

  localparam int unsigned NPORT = 2;
  localparam int unsigned SIDE_L = 0;
  localparam int unsigned SIDE_R = 1;
endpackage

// File: rtl/dpr_arbiter.sv
module dpr_arbiter
  import dpr_pkg::*;
#(
  parameter int unsigned AW = 11
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      slave_en,
  input  logic [NPORT-1:0]          act,
  input  logic [NPORT-1:0][AW-1:0]  addr,
  output logic [NPORT-1:0]          busy_n,
  output grant_e                    win
);
  logic [NPORT-1:0]         prev_act_q;
  logic [NPORT-1:0][AW-1:0] prev_addr_q;
  logic [NPORT-1:0]         settled;
  logic                     match;
  logic                     held_q;
  grant_e                   held_win_q;
  grant_e                   win_now;

  // a side is settled when it sat at this same address last cycle
  for (genvar p = 0; p < NPORT; p++) begin : g_settle
    assign settled[p] = act[p] & prev_act_q[p] & (prev_addr_q[p] == addr[p]);
  end

  assign match = act[SIDE_L] & act[SIDE_R] & (addr[SIDE_L] == addr[SIDE_R]);

  always_comb begin
    if (!match || slave_en)                     win_now = GRANT_NONE;
    else if (held_q)                            win_now = held_win_q;
    else if (settled[SIDE_R] && !settled[SIDE_L]) win_now = GRANT_RIGHT;
    else                                        win_now = GRANT_LEFT;
  end

  assign win              = win_now;
  assign busy_n[SIDE_L]   = (win_now != GRANT_RIGHT);
  assign busy_n[SIDE_R]   = (win_now != GRANT_LEFT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_act_q  <= '0;
      prev_addr_q <= '0;
      held_q      <= 1'b0;
      held_win_q  <= GRANT_NONE;
    end else begin
      prev_act_q  <= act;
      prev_addr_q <= addr;
      held_q      <= (win_now != GRANT_NONE);
      held_win_q  <= win_now;
    end
  end
endmodule

// File: rtl/dpr_store.sv
module dpr_store
  import dpr_pkg::*;
#(
  parameter int unsigned AW = 11,
  parameter int unsigned DW = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      slave_en,
  input  logic [NPORT-1:0]          ce_n,
  input  logic [NPORT-1:0]          we_n,
  input  logic [NPORT-1:0]          oe_n,
  input  logic [NPORT-1:0][AW-1:0]  addr,
  input  logic [NPORT-1:0][DW-1:0]  wdata,
  input  logic [NPORT-1:0]          busy_arb_n,
  input  logic [NPORT-1:0]          busy_ext_n,
  output logic [NPORT-1:0][DW-1:0]  rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0]    mem [DEPTH];
  logic [NPORT-1:0] wr_ok;

  for (genvar p = 0; p < NPORT; p++) begin : g_wgate
    assign wr_ok[p] = ~ce_n[p] & ~we_n[p] &
                      (slave_en ? busy_ext_n[p] : busy_arb_n[p]);
  end

  // right first, so left lands last when both hit one word in slave mode
  always_ff @(posedge clk) begin
    if (wr_ok[SIDE_R]) mem[addr[SIDE_R]] <= wdata[SIDE_R];
    if (wr_ok[SIDE_L]) mem[addr[SIDE_L]] <= wdata[SIDE_L];
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_rd
    logic          lost_q;
    logic          we_q;
    logic [DW-1:0] rd_q;
    logic          lost_now;
    logic          rd_en;
    logic          hold;

    assign lost_now = ~slave_en & ~busy_arb_n[p];
    assign rd_en    = ~ce_n[p] & we_n[p] & ~oe_n[p];
    assign hold     = lost_now & lost_q & (we_q == we_n[p]);
    assign rdata[p] = rd_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lost_q <= 1'b0;
        we_q   <= 1'b1;
        rd_q   <= '0;
      end else begin
        lost_q <= lost_now;
        we_q   <= we_n[p];
        if (!rd_en)     rd_q <= '0;
        else if (!hold) rd_q <= mem[addr[p]];
      end
    end
  end
endmodule

// File: rtl/dpr_collision_ram.sv
module dpr_collision_ram
  import dpr_pkg::*;
#(
  parameter int unsigned AW = 11,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slave_en,
  input  logic          ce_l_n,
  input  logic          we_l_n,
  input  logic          oe_l_n,
  input  logic [AW-1:0] addr_l,
  input  logic [DW-1:0] wdata_l,
  output logic [DW-1:0] rdata_l,
  output logic          busy_l_n,
  input  logic          busy_l_in_n,
  input  logic          ce_r_n,
  input  logic          we_r_n,
  input  logic          oe_r_n,
  input  logic [AW-1:0] addr_r,
  input  logic [DW-1:0] wdata_r,
  output logic [DW-1:0] rdata_r,
  output logic          busy_r_n,
  input  logic          busy_r_in_n,
  output logic [1:0]    grant
);
  logic [NPORT-1:0]         ce_v, we_v, oe_v, busy_v, busy_in_v;
  logic [NPORT-1:0][AW-1:0] addr_v;
  logic [NPORT-1:0][DW-1:0] wdata_v, rdata_v;
  grant_e                   win;

  assign ce_v      = {ce_r_n, ce_l_n};
  assign we_v      = {we_r_n, we_l_n};
  assign oe_v      = {oe_r_n, oe_l_n};
  assign addr_v    = {addr_r, addr_l};
  assign wdata_v   = {wdata_r, wdata_l};
  assign busy_in_v = {busy_r_in_n, busy_l_in_n};

  dpr_arbiter #(.AW(AW)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .slave_en(slave_en),
    .act     (~ce_v),
    .addr    (addr_v),
    .busy_n  (busy_v),
    .win     (win)
  );

  dpr_store #(.AW(AW), .DW(DW)) u_mem (
    .clk       (clk),
    .rst_n     (rst_n),
    .slave_en  (slave_en),
    .ce_n      (ce_v),
    .we_n      (we_v),
    .oe_n      (oe_v),
    .addr      (addr_v),
    .wdata     (wdata_v),
    .busy_arb_n(busy_v),
    .busy_ext_n(busy_in_v),
    .rdata     (rdata_v)
  );

  assign busy_l_n = busy_v[SIDE_L];
  assign busy_r_n = busy_v[SIDE_R];
  assign rdata_l  = rdata_v[SIDE_L];
  assign rdata_r  = rdata_v[SIDE_R];
  assign grant    = win;
endmodule

// File: rtl/dpr_collision_sva.sv
module dpr_collision_sva #(
  parameter int unsigned AW = 11,
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          slave_en,
  input logic          ce_l_n,
  input logic          ce_r_n,
  input logic          we_r_n,
  input logic          oe_r_n,
  input logic [AW-1:0] addr_l,
  input logic [AW-1:0] addr_r,
  input logic [DW-1:0] rdata_r,
  input logic          busy_l_n,
  input logic          busy_r_n,
  input logic [1:0]    grant
);
  a_r2_one_loser: assert property (@(posedge clk) disable iff (!rst_n)
    !(!busy_l_n && !busy_r_n));

  a_r2_busy_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_l_n || !busy_r_n) |-> (!ce_l_n && !ce_r_n && addr_l == addr_r));

  a_r9_grant_code: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  a_r5_grant_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != 2'b00) |=> (grant == 2'b00 || $stable(grant)));

  a_r8_slave_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    slave_en |-> (busy_l_n && busy_r_n && grant == 2'b00));

  a_r7_loser_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !slave_en && !busy_r_n && $past(!busy_r_n) &&
     $stable(we_r_n) && we_r_n && !ce_r_n && !oe_r_n) |=> $stable(rdata_r));
endmodule

bind dpr_collision_ram dpr_collision_sva #(.AW(AW), .DW(DW)) u_sva (
  .clk     (clk),
  .rst_n   (rst_n),
  .slave_en(slave_en),
  .ce_l_n  (ce_l_n),
  .ce_r_n  (ce_r_n),
  .we_r_n  (we_r_n),
  .oe_r_n  (oe_r_n),
  .addr_l  (addr_l),
  .addr_r  (addr_r),
  .rdata_r (rdata_r),
  .busy_l_n(busy_l_n),
  .busy_r_n(busy_r_n),
  .grant   (grant)
);

// File: tb/tb_dpr_collision_ram.sv
module tb_dpr_collision_ram;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slave_en = 1'b0;
  logic        ce_l_n = 1'b1, we_l_n = 1'b1, oe_l_n = 1'b1;
  logic [10:0] addr_l = '0;
  logic [7:0]  wdata_l = '0;
  logic [7:0]  rdata_l;
  logic        busy_l_n;
  logic        busy_l_in_n = 1'b1;
  logic        ce_r_n = 1'b1, we_r_n = 1'b1, oe_r_n = 1'b1;
  logic [10:0] addr_r = '0;
  logic [7:0]  wdata_r = '0;
  logic [7:0]  rdata_r;
  logic        busy_r_n;
  logic        busy_r_in_n = 1'b1;
  logic [1:0]  grant;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dpr_collision_ram dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic side_l(input logic ce, input logic we, input logic oe,
                        input logic [10:0] a, input logic [7:0] d);
    ce_l_n = ce; we_l_n = we; oe_l_n = oe; addr_l = a; wdata_l = d;
  endtask

  task automatic side_r(input logic ce, input logic we, input logic oe,
                        input logic [10:0] a, input logic [7:0] d);
    ce_r_n = ce; we_r_n = we; oe_r_n = oe; addr_r = a; wdata_r = d;
  endtask

  task automatic idle();
    side_l(1, 1, 1, '0, '0);
    side_r(1, 1, 1, '0, '0);
    tick();
  endtask

  task automatic t_reset();
    #1;
    chk("R10 rdata_l in reset", rdata_l, 8'h00);
    chk("R10 busy_l_n in reset", busy_l_n, 1'b1);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    chk("R10 rdata_r after reset", rdata_r, 8'h00);
    chk("R10 busy_r_n after reset", busy_r_n, 1'b1);
    chk("R10 grant after reset", grant, 2'b00);
  endtask

  task automatic t_basic();
    side_l(0, 0, 1, 11'h010, 8'hA5); tick();
    side_l(1, 1, 1, '0, '0);
    side_r(0, 1, 0, 11'h010, '0); tick();
    chk("R1 right reads left write", rdata_r, 8'hA5);
    side_r(0, 1, 1, 11'h010, '0); tick();
    chk("R1 oe high gives zero", rdata_r, 8'h00);
    side_r(1, 0, 1, 11'h010, 8'h33); tick();
    side_r(0, 1, 0, 11'h010, '0); tick();
    chk("R1 deselected write ignored", rdata_r, 8'hA5);
    idle();
  endtask

  task automatic t_tie();
    side_l(0, 1, 0, 11'h020, '0);
    side_r(0, 1, 0, 11'h020, '0);
    #1;
    chk("R4 tie grant left", grant, 2'b01);
    chk("R4 tie right busy", busy_r_n, 1'b0);
    chk("R4 tie left free", busy_l_n, 1'b1);
    idle();
  endtask

  task automatic t_arrival();
    side_r(0, 1, 0, 11'h030, '0);
    side_l(0, 1, 0, 11'h031, '0);
    #1;
    chk("R2 no match no busy", busy_l_n, 1'b1);
    tick();
    side_l(0, 1, 0, 11'h030, '0);
    #1;
    chk("R3 settled right wins", grant, 2'b10);
    chk("R3 newcomer left busy", busy_l_n, 1'b0);
    tick();
    chk("R5 grant held next cycle", grant, 2'b10);
    side_l(0, 1, 0, 11'h031, '0);
    #1;
    chk("R2 busy released on mismatch", busy_l_n, 1'b1);
    chk("R9 grant none on mismatch", grant, 2'b00);
    idle();
    // select-based arrival: left present first, right selects second
    side_l(0, 1, 0, 11'h032, '0); tick();
    side_r(0, 1, 0, 11'h032, '0);
    #1;
    chk("R3 late select loses", busy_r_n, 1'b0);
    idle();
  endtask

  task automatic t_freeze();
    side_l(0, 0, 1, 11'h040, 8'h11); tick();
    side_l(0, 1, 0, 11'h040, '0); tick();
    side_r(0, 1, 0, 11'h040, '0); tick();
    chk("R7 first busy cycle loads", rdata_r, 8'h11);
    side_l(0, 0, 1, 11'h040, 8'h22); tick();
    chk("R7 loser frozen during winner write", rdata_r, 8'h11);
    side_l(0, 1, 0, 11'h040, '0); tick();
    chk("R7 loser still frozen", rdata_r, 8'h11);
    chk("R1 winner sees own write", rdata_l, 8'h22);
    side_l(1, 1, 1, '0, '0); tick();
    chk("R7 released after busy rises", rdata_r, 8'h22);
    idle();
  endtask

  task automatic t_drop();
    side_l(0, 0, 1, 11'h050, 8'h5C); tick();
    side_l(0, 1, 0, 11'h050, '0); tick();
    side_r(0, 0, 1, 11'h050, 8'hEE);
    #1;
    chk("R6 writing loser busy", busy_r_n, 1'b0);
    tick(); tick();
    side_l(1, 1, 1, '0, '0);
    side_r(0, 1, 0, 11'h050, '0); tick();
    chk("R6 loser write dropped", rdata_r, 8'h5C);
    idle();
  endtask

  task automatic t_slave();
    slave_en = 1'b1;
    side_l(0, 1, 0, 11'h060, '0);
    side_r(0, 1, 0, 11'h060, '0);
    #1;
    chk("R8 slave busy_l high", busy_l_n, 1'b1);
    chk("R8 slave grant none", grant, 2'b00);
    idle();
    side_r(0, 0, 1, 11'h061, 8'h77); tick();
    busy_r_in_n = 1'b0;
    side_r(0, 0, 1, 11'h061, 8'h99); tick();
    busy_r_in_n = 1'b1;
    side_r(0, 1, 0, 11'h061, '0); tick();
    chk("R8 inhibited write blocked", rdata_r, 8'h77);
    side_r(0, 0, 1, 11'h061, 8'h99); tick();
    side_r(0, 1, 0, 11'h061, '0); tick();
    chk("R8 write after inhibit lifts", rdata_r, 8'h99);
    slave_en = 1'b0;
    idle();
  endtask

  initial begin
    t_reset();
    t_basic();
    t_tie();
    t_arrival();
    t_freeze();
    t_drop();
    t_slave();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule